// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock, serial data) into pairs of 24-bit two's-complement samples. A 3-bit format code picks the framing: 16-bit, 20-bit or 24-bit words aligned to the end of each half-frame, a 24-bit word starting at the frame-clock transition, or the I2S framing with a one-bit delay. Shorter words come out left-aligned in the 24-bit sample with zeros in the unused low bits.

All bit capture runs on the bit clock. Once the right word of a frame is complete, the finished left/right pair crosses to the system clock through a toggle request and acknowledge. The system side then presents both samples together with a one-cycle valid pulse. A pair that completes while the previous pair is still unacknowledged is dropped. The held data therefore never changes while it is being sampled.

The bit-clock sequencer has five states. RX_PRIME lasts one bit and loads the frame-clock history. RX_HUNT waits for the first frame-clock transition and discards the partial half-frame in progress. RX_DELAY absorbs the I2S delay bit. RX_BODY shifts word bits in. RX_TAIL ignores the bits after a 24-bit window. A frame-clock transition from RX_DELAY, RX_BODY or RX_TAIL completes a word and enters RX_DELAY (I2S) or RX_BODY (any other format). RX_DELAY moves to RX_BODY on the next bit. RX_BODY moves to RX_TAIL after the 24th bit in the two window formats.

The pairing stage has two states. PR_NEED_LEFT moves to PR_NEED_RIGHT when a left word completes. PR_NEED_RIGHT returns to PR_NEED_LEFT when a right word completes. The system-side stage has two states. SK_WAIT moves to SK_EMIT when a new request is seen. SK_EMIT returns to SK_WAIT after one cycle.

Top module: `audio_serial_rx`

## Requirements
- R1: Format code 0 takes the last 16 bits of each half-frame (MSB first) as the word and outputs it as sample[23:8], with sample[7:0] zero; 16 bit clocks per half-frame are enough.
- R2: Format code 1 takes the last 20 bits of each half-frame as the word and outputs it as sample[23:4], with sample[3:0] zero.
- R3: Format code 2 takes the 24 bits starting with the bit captured at the first bit-clock rising edge after a frame-clock transition; later bits of that half-frame are ignored.
- R4: Format code 3 (I2S) ignores the first bit after a frame-clock transition and takes the next 24 bits; frame clock low marks the left channel.
- R5: Format code 4 takes the last 24 bits of each half-frame as the word.
- R6: In every format other than code 3, frame clock high marks the left channel and low marks the right channel.
- R7: Format codes 5, 6 and 7 behave exactly as code 0.
- R8: In the end-aligned formats (codes 0, 1 and 4), bits that come before the word in a half-frame have no effect on the output.
- R9: Left and right samples of one frame appear together once the right word has completed, with sample_valid high for exactly one system clock cycle per frame; the outputs do not change between pulses.
- R10: The half-frame in progress when reset ends is discarded, and a right word that has no preceding left word in the same frame produces no output.
- R11: While and after reset, left_out and right_out are zero and sample_valid is low until the first complete frame.
- R12: The pair held for the system side and its request toggle stay unchanged until the system side has acknowledged the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the output side |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| bclk | input | 1 | Serial bit clock; data sampled on its rising edge |
| lrclk | input | 1 | Frame clock marking the channel of each half-frame |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_code | input | 3 | Framing select, codes 0 to 4, with 5 to 7 treated as 0 |
| left_out | output | 24 | Left sample, two's complement |
| right_out | output | 24 | Right sample, two's complement |
| sample_valid | output | 1 | One-cycle pulse in sys_clk when a new pair is presented |

## Verification
The hardest situation to reach from the ports is the start of a stream. The receiver has to recognise and throw away a half-frame it joined part-way through, and must not emit an unpaired right word. Every test section therefore begins from reset with a full half-frame of random data at the right-channel level. Any leak of that data would appear as an extra pair in the scoreboard. The don't-care bits that come before an end-aligned word are filled with random values, and frames are sent back to back so that the request/acknowledge crossing must complete within one frame.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int SHORT_W   = 16;
    localparam int MID_W     = 20;
    localparam int BIT_CNT_W = $clog2(SAMPLE_W + 1);

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'd0,
        FMT_LSB20 = 3'd1,
        FMT_MSB24 = 3'd2,
        FMT_I2S   = 3'd3,
        FMT_LSB24 = 3'd4
    } fmt_e;

    typedef enum logic [2:0] {
        RX_PRIME,
        RX_HUNT,
        RX_DELAY,
        RX_BODY,
        RX_TAIL
    } rx_state_e;

    typedef enum logic {
        PR_NEED_LEFT,
        PR_NEED_RIGHT
    } pair_state_e;

    typedef enum logic {
        SK_WAIT,
        SK_EMIT
    } sink_state_e;

    // Reserved codes fall back to the 16-bit end-aligned framing
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        fmt_e f;
        case (code)
            3'd1:    f = FMT_LSB20;
            3'd2:    f = FMT_MSB24;
            3'd3:    f = FMT_I2S;
            3'd4:    f = FMT_LSB24;
            default: f = FMT_LSB16;
        endcase
        return f;
    endfunction

    function automatic logic is_end_aligned(input fmt_e f);
        return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
    endfunction

    // Left-align short words inside the full sample width
    function automatic logic [SAMPLE_W-1:0] align_word(input fmt_e f,
                                                       input logic [SAMPLE_W-1:0] sr);
        logic [SAMPLE_W-1:0] w;
        case (f)
            FMT_LSB16: w = {sr[SHORT_W-1:0], {(SAMPLE_W-SHORT_W){1'b0}}};
            FMT_LSB20: w = {sr[MID_W-1:0], {(SAMPLE_W-MID_W){1'b0}}};
            default:   w = sr;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import audio_rx_pkg::*;
(
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrclk,
    input  logic                sdata,
    input  logic [2:0]          fmt_code,
    output logic                word_stb,
    output logic [SAMPLE_W-1:0] word,
    output logic                word_left
);
    rx_state_e              state_q, state_d;
    logic                   lr_q;
    logic [BIT_CNT_W-1:0]   cnt_q;
    logic [SAMPLE_W-1:0]    sr_q;
    fmt_e                   fmt;
    logic                   i2s_mode;
    logic                   end_mode;
    logic                   frame_edge;
    logic                   window_last;
    rx_state_e              start_state;

    assign fmt         = decode_fmt(fmt_code);
    assign i2s_mode    = (fmt == FMT_I2S);
    assign end_mode    = is_end_aligned(fmt);
    assign frame_edge  = (lrclk != lr_q);
    assign window_last = (cnt_q == BIT_CNT_W'(SAMPLE_W - 1));
    assign start_state = i2s_mode ? RX_DELAY : RX_BODY;

    // State register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_PRIME: state_d = RX_HUNT;
            RX_HUNT: begin
                if (frame_edge) state_d = start_state;
            end
            RX_DELAY: begin
                if (frame_edge) state_d = start_state;
                else            state_d = RX_BODY;
            end
            RX_BODY: begin
                if (frame_edge)                     state_d = start_state;
                else if (!end_mode && window_last)  state_d = RX_TAIL;
            end
            RX_TAIL: begin
                if (frame_edge) state_d = start_state;
            end
        endcase
    end

    // Shift register, bit counter and completed-word outputs
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q      <= 1'b0;
            cnt_q     <= '0;
            sr_q      <= '0;
            word_stb  <= 1'b0;
            word      <= '0;
            word_left <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            lr_q     <= lrclk;
            if (state_q != RX_PRIME && frame_edge) begin
                if (state_q != RX_HUNT) begin
                    word_stb  <= 1'b1;
                    word      <= align_word(fmt, sr_q);
                    word_left <= i2s_mode ? ~lr_q : lr_q;
                end
                if (i2s_mode) begin
                    cnt_q <= '0;
                end else begin
                    sr_q  <= {sr_q[SAMPLE_W-2:0], sdata};
                    cnt_q <= BIT_CNT_W'(1);
                end
            end else begin
                case (state_q)
                    RX_DELAY: begin
                        sr_q  <= {sr_q[SAMPLE_W-2:0], sdata};
                        cnt_q <= BIT_CNT_W'(1);
                    end
                    RX_BODY: begin
                        sr_q <= {sr_q[SAMPLE_W-2:0], sdata};
                        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
    import audio_rx_pkg::*;
(
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                word_stb,
    input  logic [SAMPLE_W-1:0] word,
    input  logic                word_left,
    input  logic                ack_sync,
    output logic                req_tgl,
    output logic [SAMPLE_W-1:0] hold_left,
    output logic [SAMPLE_W-1:0] hold_right
);
    pair_state_e          state_q, state_d;
    logic [SAMPLE_W-1:0]  left_buf;
    logic                 publish;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PR_NEED_LEFT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_NEED_LEFT:  if (word_stb && word_left)  state_d = PR_NEED_RIGHT;
            PR_NEED_RIGHT: if (word_stb && !word_left) state_d = PR_NEED_LEFT;
        endcase
    end

    // A right word closes the frame; it is sent only if the previous pair was taken
    assign publish = (state_q == PR_NEED_RIGHT) && word_stb && !word_left
                     && (req_tgl == ack_sync);

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_buf   <= '0;
            hold_left  <= '0;
            hold_right <= '0;
            req_tgl    <= 1'b0;
        end else begin
            if (word_stb && word_left) left_buf <= word;
            if (publish) begin
                hold_left  <= left_buf;
                hold_right <= word;
                req_tgl    <= ~req_tgl;
            end
        end
    end
endmodule

// File: rtl/aud_rx_sink.sv
module aud_rx_sink
    import audio_rx_pkg::*;
(
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic                req_sync,
    input  logic [SAMPLE_W-1:0] hold_left,
    input  logic [SAMPLE_W-1:0] hold_right,
    output logic                ack_tgl,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    sink_state_e state_q, state_d;
    logic        pending;

    assign pending = (req_sync != ack_tgl);

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SK_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SK_WAIT: if (pending) state_d = SK_EMIT;
            SK_EMIT: state_d = SK_WAIT;
        endcase
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            left_out  <= '0;
            right_out <= '0;
            ack_tgl   <= 1'b0;
        end else begin
            if (state_q == SK_WAIT && pending) begin
                left_out  <= hold_left;
                right_out <= hold_right;
            end
            if (state_q == SK_EMIT) ack_tgl <= ~ack_tgl;
        end
    end

    assign sample_valid = (state_q == SK_EMIT);
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic                sdata,
    input  logic [2:0]          fmt_code,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    logic                word_stb;
    logic [SAMPLE_W-1:0] word;
    logic                word_left;
    logic                req_tgl;
    logic                req_sync;
    logic                ack_tgl;
    logic                ack_sync_b;
    logic [SAMPLE_W-1:0] hold_left;
    logic [SAMPLE_W-1:0] hold_right;

    aud_rx_deser u_deser (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .lrclk     (lrclk),
        .sdata     (sdata),
        .fmt_code  (fmt_code),
        .word_stb  (word_stb),
        .word      (word),
        .word_left (word_left)
    );

    aud_rx_pair u_pair (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .word_stb   (word_stb),
        .word       (word),
        .word_left  (word_left),
        .ack_sync   (ack_sync_b),
        .req_tgl    (req_tgl),
        .hold_left  (hold_left),
        .hold_right (hold_right)
    );

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    aud_rx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (bclk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_sync_b)
    );

    aud_rx_sink u_sink (
        .sys_clk      (sys_clk),
        .rst_n        (rst_n),
        .req_sync     (req_sync),
        .hold_left    (hold_left),
        .hold_right   (hold_right),
        .ack_tgl      (ack_tgl),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (sample_valid)
    );
endmodule

// File: rtl/aud_rx_checker.sv
module aud_rx_checker
    import audio_rx_pkg::*;
(
    input logic                sys_clk,
    input logic                bclk,
    input logic                rst_n,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                req_tgl,
    input logic                ack_sync_b,
    input logic [SAMPLE_W-1:0] hold_left,
    input logic [SAMPLE_W-1:0] hold_right,
    input logic                word_stb,
    input logic                word_left
);
    AST_VALID_SINGLE: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid); // R9

    AST_OUT_HOLD: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_out) && $stable(right_out))); // R9

    AST_HOLD_UNTIL_ACK: assert property (@(posedge bclk) disable iff (!rst_n)
        (req_tgl != ack_sync_b) |=> ($stable(hold_left) && $stable(hold_right))); // R12

    AST_REQ_UNTIL_ACK: assert property (@(posedge bclk) disable iff (!rst_n)
        (req_tgl != ack_sync_b) |=> $stable(req_tgl)); // R12

    AST_REQ_ON_RIGHT: assert property (@(posedge bclk) disable iff (!rst_n)
        !$stable(req_tgl) |-> $past(word_stb && !word_left)); // R9
endmodule

bind audio_serial_rx aud_rx_checker u_chk (
    .sys_clk      (sys_clk),
    .bclk         (bclk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .left_out     (left_out),
    .right_out    (right_out),
    .req_tgl      (req_tgl),
    .ack_sync_b   (ack_sync_b),
    .hold_left    (hold_left),
    .hold_right   (hold_right),
    .word_stb     (word_stb),
    .word_left    (word_left)
);

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BCLK_HALF  = 2 * CLK_PERIOD;
    localparam int WATCHDOG   = 100000;

    logic        sys_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        bclk    = 1'b0;
    logic        lrclk   = 1'b0;
    logic        sdata   = 1'b0;
    logic [2:0]  fmt_code = 3'd0;
    logic [23:0] left_out, right_out;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit prev_valid = 1'b0;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    audio_serial_rx u_audio_serial_rx (
        .sys_clk      (sys_clk),
        .rst_n        (rst_n),
        .bclk         (bclk),
        .lrclk        (lrclk),
        .sdata        (sdata),
        .fmt_code     (fmt_code),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (sample_valid)
    );

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    // Watchdog
    always @(posedge sys_clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Monitor / scoreboard
    always @(negedge sys_clk) begin
        if (rst_n && sample_valid) begin
            checks++;
            if (prev_valid) begin
                errors++;
                $display("FAIL R9 valid held two cycles: got 1 expected 0");
            end else if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected pair: got %h/%h expected none", left_out, right_out);
            end else begin
                logic [47:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (left_out !== e[47:24] || right_out !== e[23:0]) begin
                    errors++;
                    $display("FAIL %s pair: got %h/%h expected %h/%h",
                             t, left_out, right_out, e[47:24], e[23:0]);
                end
            end
        end
        prev_valid = rst_n && sample_valid;
    end

    task automatic do_reset();
        bclk  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge sys_clk);
        @(negedge sys_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge sys_clk);
    endtask

    task automatic drive_bit(input logic lvl, input logic b);
        lrclk = lvl;
        sdata = b;
        #(BCLK_HALF) bclk = 1'b1;
        #(BCLK_HALF) bclk = 1'b0;
    endtask

    // Serialise one half-frame according to the framing rules
    task automatic send_half(input logic lvl, input logic [23:0] raw,
                             input int eff, input int n, input int hl);
        for (int i = 0; i < hl; i++) begin
            bit b;
            b = 1'($urandom);
            if (eff == 2) begin
                if (i < 24) b = raw[23-i];
            end else if (eff == 3) begin
                if (i >= 1 && i <= 24) b = raw[24-i];
            end else if (i >= hl - n) begin
                b = raw[hl-1-i];
            end
            drive_bit(lvl, b);
        end
    endtask

    task automatic run_section(input logic [2:0] code, input int hl,
                               input int frames, input string tag);
        int   eff;
        int   n;
        logic left_lvl;
        eff      = (code > 3'd4) ? 0 : int'(code);
        n        = (eff == 0) ? 16 : (eff == 1) ? 20 : 24;
        left_lvl = (eff == 3) ? 1'b0 : 1'b1;
        fmt_code = code;
        do_reset();
        // Partial/unpaired right-level half-frame that must be discarded (R10)
        for (int i = 0; i < hl; i++) drive_bit(~left_lvl, 1'($urandom));
        for (int f = 0; f < frames; f++) begin
            logic [23:0] lraw, rraw, lexp, rexp;
            lraw = 24'($urandom) & 24'((1 << n) - 1);
            rraw = 24'($urandom) & 24'((1 << n) - 1);
            lexp = lraw << (24 - n);
            rexp = rraw << (24 - n);
            exp_q.push_back({lexp, rexp});
            tag_q.push_back(tag);
            send_half(left_lvl, lraw, eff, n, hl);
            send_half(~left_lvl, rraw, eff, n, hl);
        end
        drive_bit(left_lvl, 1'b0);
        drive_bit(left_lvl, 1'b0);
        repeat (40) @(negedge sys_clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9/R12 %s pairs missing: got %0d left expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        do_reset();
        // R11: reset state
        checks++;
        if (left_out !== 24'd0 || right_out !== 24'd0 || sample_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset outputs: got %h/%h/%b expected 0/0/0",
                     left_out, right_out, sample_valid);
        end
        run_section(3'd2, 32, 3, "R3 R6 R10");
        run_section(3'd2, 24, 2, "R3");
        run_section(3'd0, 16, 3, "R1 R8");
        run_section(3'd0, 32, 2, "R1 R8");
        run_section(3'd1, 32, 3, "R2 R8");
        run_section(3'd3, 32, 3, "R4");
        run_section(3'd4, 24, 2, "R5");
        run_section(3'd4, 32, 2, "R5 R8");
        run_section(3'd6, 16, 2, "R7");
        run_section(3'd7, 32, 2, "R7");
        run_section(3'd5, 20, 2, "R7 R8");
        // R11: after a fresh reset the outputs are cleared again
        do_reset();
        checks++;
        if (left_out !== 24'd0 || right_out !== 24'd0 || sample_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 outputs after reset: got %h/%h/%b expected 0/0/0",
                     left_out, right_out, sample_valid);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule